// File: doc/BRIEF.md
# Multi-Mode Serial Receive Engine

This block is the receive half of a serial port. It watches one serial data line and turns the incoming bits into bytes. Each byte goes into a receive data register. A set of status flags reports when a byte is ready and whether a parity, overrun or framing error occurred. A receive interrupt is raised when the flags call for it and the interrupt is enabled.

The engine has four modes. Mode 0 is plain asynchronous. Mode 1 is asynchronous multiprocessor, where an address/data marker bit follows the data bits. Mode 2 is clock-synchronous, with start/stop framing that can be switched on or off. Mode 3 is asynchronous in LIN style, using 8 data bits, no parity and one stop bit. Baud generation is outside the block. A strobe input marks each sampling instant. In the asynchronous modes this is an oversampling strobe running OVS times per bit. In mode 2 it is one strobe per bit. Software reads the byte with a read strobe and clears the error flags with a separate clear strobe.

Top module: `mmrx_top`

## Requirements
- R1: After reset the received byte, the A/D bit, all four flags and the interrupt are 0.
- R2: In modes 0 and 3 a frame has a start bit (0), data LSB first, then a stop bit. Each bit is sampled at its midpoint, OVS/2 strobes after the falling edge is first seen and then every OVS strobes. The byte and data-ready appear in the clock after the edge where the stop bit is sampled, and not before.
- R3: In mode 0 with `cfg_len7`=1, 7 data bits are received and bit 7 of the byte reads 0. With `cfg_par_en`=1 a parity bit follows the data. `cfg_par_odd` selects odd (1) or even (0) parity. A mismatch sets the parity error flag together with data-ready.
- R4: In mode 1 a frame carries 8 data bits, then the A/D bit, then the stop bit. The A/D bit is output on `rx_adr_flag` together with the byte.
- R5: In mode 2 with `sync_frame`=1, the first strobe that sees the line at 0 is the start bit. The next 8 strobes shift in data, and the strobe after that samples the stop bit. The byte is loaded at that stop strobe.
- R6: In mode 2 with `sync_frame`=0, every strobe shifts in one bit, LSB first. Completion and data-ready occur on the 8th strobe, with no stop bit.
- R7: A sampled stop bit of 0 sets the framing error flag together with data-ready.
- R8: When a frame completes while data-ready is still 1 (no read has happened), the overrun flag is set and data-ready stays 1.
- R9: The parity error flag stays 0 in modes 1 and 3, even when `cfg_par_en`=1.
- R10: `rx_irq` is 1 exactly when `rx_irq_en` is 1 and data-ready or any error flag is 1.
- R11: `rd_strobe` clears data-ready and `err_clr` clears all three error flags, one clock after the strobe. A completion in the same cycle wins over the clear.
- R12: In the asynchronous modes a start bit whose line reads 1 at the midpoint sample is dropped. The engine returns to idle and produces no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial receive line, idle high |
| smp_tick | input | 1 | Sampling strobe (oversampling in async modes, bit clock in mode 2) |
| mode | input | 2 | 0 normal async, 1 multiprocessor, 2 synchronous, 3 LIN-style |
| sync_frame | input | 1 | Mode 2: 1 = start/stop framing on |
| cfg_len7 | input | 1 | Mode 0: 1 = 7 data bits, 0 = 8 |
| cfg_par_en | input | 1 | Mode 0: parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| rx_irq_en | input | 1 | Receive interrupt enable |
| rd_strobe | input | 1 | Data register read, clears data-ready |
| err_clr | input | 1 | Clears the error flags |
| rx_byte | output | 8 | Received data register |
| rx_adr_flag | output | 1 | Captured address/data bit (mode 1) |
| data_rdy | output | 1 | Data-ready flag |
| perr | output | 1 | Parity error flag |
| oerr | output | 1 | Overrun error flag |
| ferr | output | 1 | Framing error flag |
| rx_irq | output | 1 | Receive interrupt |

## Verification
In the asynchronous modes, the byte and flags are due exactly 1 + OVS/2 + (n+1)·OVS clocks after the negative edge at which the start bit is driven, where n counts the data, parity and A/D bits before the stop bit. In mode 2 they are due one clock after the strobe that carries the stop bit or the 8th data bit. The driver computes this due cycle from the frame shape and pushes it with the expected values. The monitor compares outputs at the negative edge of exactly that cycle. For key cases it also checks one cycle earlier that data-ready is still 0. The clear strobes and the interrupt enable act one clock later or combinationally, and are checked at the next negative edge.

// File: rtl/mmrx_pkg.sv
package mmrx_pkg;
  localparam int DW = 8;

  typedef enum logic [1:0] {
    M_NORM = 2'd0,
    M_MPRC = 2'd1,
    M_SYNC = 2'd2,
    M_LINS = 2'd3
  } rx_mode_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_ADB,
    S_STOP
  } rx_state_t;

  // right-shift register holds a 7-bit word in its upper bits
  function automatic logic [DW-1:0] align_byte(logic [DW-1:0] s, logic seven);
    return seven ? {1'b0, s[DW-1:1]} : s;
  endfunction

  // 1 when the received parity bit does not match the chosen sense
  function automatic logic parity_bad(logic [DW-1:0] d, logic pbit, logic odd);
    return (^d) ^ pbit ^ odd;
  endfunction

  function automatic logic [3:0] last_bit_idx(rx_mode_t m, logic len7);
    return (m == M_NORM && len7) ? 4'd6 : 4'd7;
  endfunction
endpackage

// File: rtl/mmrx_framer.sv
module mmrx_framer
  import mmrx_pkg::*;
#(
  parameter int OVS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rxd,
  input  logic          tick,
  input  rx_mode_t      mode,
  input  logic          sync_frame,
  input  logic          len7,
  input  logic          par_en,
  input  logic          par_odd,
  output logic          fr_done,
  output logic [DW-1:0] fr_data,
  output logic          fr_ad,
  output logic          fr_perr,
  output logic          fr_ferr
);
  localparam int CW = (OVS > 2) ? $clog2(OVS) : 1;
  localparam logic [CW-1:0] BIT_END = CW'(OVS - 1);
  localparam logic [CW-1:0] MID_END = CW'(OVS / 2 - 1);

  rx_state_t     st;
  logic [CW-1:0] cnt;
  logic [3:0]    bidx;
  logic [DW-1:0] sreg;
  logic          ad_q, pe_q;

  logic is_sync, unframed, seven, has_par, has_ad;
  logic at_bit, at_mid;
  logic [3:0] last_idx;
  logic [DW-1:0] shifted;

  assign is_sync  = (mode == M_SYNC);
  assign unframed = is_sync & ~sync_frame;
  assign seven    = (mode == M_NORM) & len7;
  assign has_par  = (mode == M_NORM) & par_en;
  assign has_ad   = (mode == M_MPRC);
  assign last_idx = last_bit_idx(mode, len7);
  assign at_bit   = tick & (is_sync | (cnt == BIT_END));
  assign at_mid   = tick & (cnt == MID_END);
  assign shifted  = {rxd, sreg[DW-1:1]};

  always_comb begin
    fr_done = 1'b0;
    fr_data = align_byte(sreg, seven);
    fr_ad   = ad_q;
    fr_perr = pe_q;
    fr_ferr = 1'b0;
    if (st == S_STOP && at_bit) begin
      fr_done = 1'b1;
      fr_ferr = ~rxd;
    end else if (st == S_DATA && at_bit && unframed && bidx == last_idx) begin
      fr_done = 1'b1;
      fr_data = shifted;
      fr_ad   = 1'b0;
      fr_perr = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      bidx <= '0;
      sreg <= '0;
      ad_q <= 1'b0;
      pe_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (tick) begin
          pe_q <= 1'b0;
          ad_q <= 1'b0;
          cnt  <= '0;
          if (unframed) begin
            sreg <= shifted;
            bidx <= 4'd1;
            st   <= S_DATA;
          end else if (!rxd) begin
            bidx <= 4'd0;
            st   <= is_sync ? S_DATA : S_START;
          end
        end
        S_START: if (tick) begin
          if (at_mid) begin
            cnt <= '0;
            st  <= rxd ? S_IDLE : S_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DATA: begin
          if (at_bit) begin
            sreg <= shifted;
            bidx <= bidx + 4'd1;
            cnt  <= '0;
            if (bidx == last_idx)
              st <= unframed ? S_IDLE : has_par ? S_PAR : has_ad ? S_ADB : S_STOP;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_PAR: begin
          if (at_bit) begin
            pe_q <= parity_bad(align_byte(sreg, seven), rxd, par_odd);
            cnt  <= '0;
            st   <= S_STOP;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_ADB: begin
          if (at_bit) begin
            ad_q <= rxd;
            cnt  <= '0;
            st   <= S_STOP;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_STOP: begin
          if (at_bit) begin
            cnt <= '0;
            st  <= S_IDLE;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R12: a start bit that reads high at its midpoint returns to idle
  a_r12_false_start: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_START && tick && cnt == MID_END && rxd) |=> (st == S_IDLE));

  // R5: framed sync mode takes the low strobe as the start bit and goes to data
  a_r5_sync_start: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && tick && mode == M_SYNC && sync_frame && !rxd) |=> (st == S_DATA));

  // R6: unframed sync completion never reports a framing error
  a_r6_unframed_no_fe: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_done && mode == M_SYNC && !sync_frame) |-> !fr_ferr);
endmodule

// File: rtl/mmrx_status.sv
module mmrx_status
  import mmrx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fr_done,
  input  logic [DW-1:0] fr_data,
  input  logic          fr_ad,
  input  logic          fr_perr,
  input  logic          fr_ferr,
  input  rx_mode_t      mode,
  input  logic          rd_strobe,
  input  logic          err_clr,
  input  logic          irq_en,
  output logic [DW-1:0] rx_byte,
  output logic          rx_adr_flag,
  output logic          data_rdy,
  output logic          perr,
  output logic          oerr,
  output logic          ferr,
  output logic          rx_irq
);
  logic pe_evt, oe_evt, fe_evt;

  assign pe_evt = fr_done & fr_perr & (mode == M_NORM);
  assign oe_evt = fr_done & data_rdy & ~rd_strobe;
  assign fe_evt = fr_done & fr_ferr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_byte     <= '0;
      rx_adr_flag <= 1'b0;
      data_rdy    <= 1'b0;
      perr        <= 1'b0;
      oerr        <= 1'b0;
      ferr        <= 1'b0;
    end else begin
      if (fr_done) begin
        rx_byte     <= fr_data;
        rx_adr_flag <= fr_ad;
      end
      data_rdy <= fr_done | (data_rdy & ~rd_strobe);
      perr     <= (perr & ~err_clr) | pe_evt;
      oerr     <= (oerr & ~err_clr) | oe_evt;
      ferr     <= (ferr & ~err_clr) | fe_evt;
    end
  end

  assign rx_irq = irq_en & (data_rdy | perr | oerr | ferr);

  // R2: completion always leaves data-ready set
  a_r2_done_sets_rdy: assert property (@(posedge clk) disable iff (!rst_n)
    fr_done |=> data_rdy);

  // R8: completion over unread data raises overrun
  a_r8_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_done && data_rdy && !rd_strobe) |=> oerr);

  // R9: completions in modes 1 and 3 never raise parity error
  a_r9_no_pe_mode13: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_done && mode[0] && !perr) |=> !perr);

  // R10: no interrupt without the enable
  a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> irq_en);

  // R11: a read with no completion clears data-ready
  a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !fr_done) |=> !data_rdy);
endmodule

// File: rtl/mmrx_top.sv
module mmrx_top
  import mmrx_pkg::*;
#(
  parameter int OVS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  input  logic       smp_tick,
  input  logic [1:0] mode,
  input  logic       sync_frame,
  input  logic       cfg_len7,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       rx_irq_en,
  input  logic       rd_strobe,
  input  logic       err_clr,
  output logic [7:0] rx_byte,
  output logic       rx_adr_flag,
  output logic       data_rdy,
  output logic       perr,
  output logic       oerr,
  output logic       ferr,
  output logic       rx_irq
);
  rx_mode_t      mode_e;
  logic          fr_done, fr_ad, fr_perr, fr_ferr;
  logic [DW-1:0] fr_data;

  assign mode_e = rx_mode_t'(mode);

  mmrx_framer #(.OVS(OVS)) u_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .rxd        (rxd),
    .tick       (smp_tick),
    .mode       (mode_e),
    .sync_frame (sync_frame),
    .len7       (cfg_len7),
    .par_en     (cfg_par_en),
    .par_odd    (cfg_par_odd),
    .fr_done    (fr_done),
    .fr_data    (fr_data),
    .fr_ad      (fr_ad),
    .fr_perr    (fr_perr),
    .fr_ferr    (fr_ferr)
  );

  mmrx_status u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .fr_done     (fr_done),
    .fr_data     (fr_data),
    .fr_ad       (fr_ad),
    .fr_perr     (fr_perr),
    .fr_ferr     (fr_ferr),
    .mode        (mode_e),
    .rd_strobe   (rd_strobe),
    .err_clr     (err_clr),
    .irq_en      (rx_irq_en),
    .rx_byte     (rx_byte),
    .rx_adr_flag (rx_adr_flag),
    .data_rdy    (data_rdy),
    .perr        (perr),
    .oerr        (oerr),
    .ferr        (ferr),
    .rx_irq      (rx_irq)
  );
endmodule

// File: tb/mmrx_top_tb.sv
module mmrx_top_tb_top;
  localparam int CLK_P = 10;
  localparam int OVS   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1, smp_tick = 1'b0, sync_frame = 1'b0;
  logic cfg_len7 = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic rx_irq_en = 1'b1, rd_strobe = 1'b0, err_clr = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [7:0] rx_byte;
  logic rx_adr_flag, data_rdy, perr, oerr, ferr, rx_irq;

  int cyc = 0, total = 0, bad = 0, pending = 0;

  typedef struct {
    int         due;
    logic [7:0] d;
    bit         chk_d;
    logic       ad, rdy, pe, oe, fe;
    string      tag;
  } exp_t;
  exp_t q[$];

  mmrx_top #(.OVS(OVS)) dut_i (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .smp_tick(smp_tick), .mode(mode),
    .sync_frame(sync_frame), .cfg_len7(cfg_len7), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .rx_irq_en(rx_irq_en), .rd_strobe(rd_strobe),
    .err_clr(err_clr), .rx_byte(rx_byte), .rx_adr_flag(rx_adr_flag),
    .data_rdy(data_rdy), .perr(perr), .oerr(oerr), .ferr(ferr), .rx_irq(rx_irq)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] expv);
    total++;
    if (got !== expv) begin
      bad++;
      $display("FAIL %s: got %0h exp %0h", tag, got, expv);
    end
  endtask

  function automatic logic even_bit(logic [6:0] d);
    int n = 0;
    for (int i = 0; i < 7; i++) if (d[i]) n++;
    return (n % 2) == 1;
  endfunction

  function automatic exp_t mk(logic [7:0] d, bit cd, logic ad, logic rdy,
                              logic pe, logic oe, logic fe, string tag);
    exp_t e;
    e.due = 0; e.d = d; e.chk_d = cd; e.ad = ad; e.rdy = rdy;
    e.pe = pe; e.oe = oe; e.fe = fe; e.tag = tag;
    return e;
  endfunction

  // monitor: compare outputs at the due cycle of each expected item
  initial begin
    forever begin
      exp_t e;
      while (q.size() == 0) @(negedge clk);
      e = q.pop_front();
      while (cyc < e.due) @(negedge clk);
      if (e.chk_d) begin
        chk({e.tag, " byte"}, rx_byte, e.d);
        chk({e.tag, " adbit"}, rx_adr_flag, e.ad);
      end
      chk({e.tag, " rdy"}, data_rdy, e.rdy);
      chk({e.tag, " pe"}, perr, e.pe);
      chk({e.tag, " oe"}, oerr, e.oe);
      chk({e.tag, " fe"}, ferr, e.fe);
      chk({e.tag, " R10 irq"}, rx_irq, rx_irq_en & (e.rdy | e.pe | e.oe | e.fe));
      pending--;
    end
  end

  // async frame: start bit, then bits[0..n] where bits[n] is the stop bit
  task automatic send_async(logic [11:0] bits, int n, exp_t e, bit pre);
    int due = cyc + 1 + OVS/2 + (n + 1) * OVS;
    if (pre) begin
      exp_t p = mk(8'h00, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 early");
      p.due = due - 1; q.push_back(p); pending++;
    end
    e.due = due; q.push_back(e); pending++;
    rxd = 1'b0;
    repeat (OVS) @(negedge clk);
    for (int i = 0; i <= n; i++) begin
      rxd = bits[i];
      repeat (OVS) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (2 * OVS) @(negedge clk);
  endtask

  task automatic sbit(logic b, bit push, exp_t e);
    if (push) begin
      e.due = cyc + 1; q.push_back(e); pending++;
    end
    rxd = b; smp_tick = 1'b1;
    @(negedge clk); smp_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd_clr(string tag);
    rd_strobe = 1'b1; err_clr = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0; err_clr = 1'b0;
    chk({tag, " R11 rdy clr"}, data_rdy, 1'b0);
    chk({tag, " R11 err clr"}, {perr, oerr, ferr}, 3'b000);
    @(negedge clk);
  endtask

  task automatic wait_mon();
    while (pending > 0) @(negedge clk);
  endtask

  initial begin
    exp_t dummy;
    logic p;
    dummy = mk(8'h00, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "none");
    repeat (3) @(negedge clk);
    chk("R1 byte", rx_byte, 8'h00);
    chk("R1 flags", {rx_adr_flag, data_rdy, perr, oerr, ferr, rx_irq}, 6'b0);
    rst_n = 1'b1;
    @(negedge clk);
    smp_tick = 1'b1;
    repeat (2) @(negedge clk);

    // R2: mode 0 8N1
    send_async({3'b111, 1'b1, 8'hA5}, 8, mk(8'hA5, 1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R2 8N1"), 1);
    wait_mon(); rd_clr("R2");

    // R3: 7 data bits, even parity, correct
    cfg_len7 = 1'b1; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
    p = even_bit(7'h35);
    send_async({4'b1111, 1'b1, p, 7'h35}, 8, mk(8'h35, 1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R3 7E1"), 0);
    wait_mon(); rd_clr("R3");

    // R3: odd parity expected, even bit sent -> parity error
    cfg_par_odd = 1'b1;
    send_async({4'b1111, 1'b1, p, 7'h35}, 8, mk(8'h35, 1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R3 7O1 bad"), 0);
    wait_mon(); rd_clr("R3b");
    cfg_len7 = 1'b0;

    // R4 / R9: multiprocessor mode, parity config ignored
    mode = 2'd1;
    send_async({2'b11, 1'b1, 1'b1, 8'h3C}, 9, mk(8'h3C, 1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R4 R9 ad1"), 0);
    wait_mon(); rd_clr("R4");
    send_async({2'b11, 1'b1, 1'b0, 8'hC3}, 9, mk(8'hC3, 1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R4 ad0"), 0);
    wait_mon(); rd_clr("R4b");

    // R9: LIN-style mode, 8N1 with parity enable set
    mode = 2'd3;
    send_async({3'b111, 1'b1, 8'h6E}, 8, mk(8'h6E, 1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R9 mode3"), 1);
    wait_mon(); rd_clr("R9");
    mode = 2'd0; cfg_par_en = 1'b0;

    // R7: stop bit 0
    send_async({3'b111, 1'b0, 8'h12}, 8, mk(8'h12, 0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R7 async fe"), 0);
    wait_mon(); rd_clr("R7");

    // R8: two frames with no read between
    send_async({3'b111, 1'b1, 8'h11}, 8, mk(8'h11, 1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R8 first"), 0);
    send_async({3'b111, 1'b1, 8'h22}, 8, mk(8'h22, 0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R8 second"), 0);
    wait_mon(); rd_clr("R8");

    // R12: short low glitch is dropped, then a good frame still works
    rxd = 1'b0; repeat (2) @(negedge clk); rxd = 1'b1;
    repeat (3 * OVS) @(negedge clk);
    chk("R12 no byte", data_rdy, 1'b0);
    send_async({3'b111, 1'b1, 8'h5A}, 8, mk(8'h5A, 1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R12 after"), 0);
    wait_mon(); rd_clr("R12");

    // R10: interrupt held off by the enable
    rx_irq_en = 1'b0;
    send_async({3'b111, 1'b1, 8'h81}, 8, mk(8'h81, 1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R10 ie0"), 0);
    wait_mon();
    chk("R10 irq off", rx_irq, 1'b0);
    rx_irq_en = 1'b1; #1;
    chk("R10 irq on", rx_irq, 1'b1);
    @(negedge clk); rd_clr("R10");

    // R5: sync framed
    smp_tick = 1'b0; mode = 2'd2; sync_frame = 1'b1;
    repeat (2) @(negedge clk);
    sbit(1'b0, 0, dummy);
    for (int i = 0; i < 8; i++) sbit(8'h96 >> i, 0, dummy);
    sbit(1'b1, 1, mk(8'h96, 1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R5 sync"));
    wait_mon(); rd_clr("R5");

    // R7: sync framed stop bit 0
    sbit(1'b0, 0, dummy);
    for (int i = 0; i < 8; i++) sbit(8'h0F >> i, 0, dummy);
    sbit(1'b0, 1, mk(8'h0F, 0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R7 sync fe"));
    rxd = 1'b1;
    wait_mon(); rd_clr("R7b");

    // R6: sync unframed, completion on 8th strobe
    sync_frame = 1'b0;
    for (int i = 0; i < 7; i++) sbit(8'h5C >> i, 0, dummy);
    chk("R6 early rdy", data_rdy, 1'b0);
    sbit(1'b0, 1, mk(8'h5C, 1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R6 unframed"));
    wait_mon(); rd_clr("R6");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule